// File: doc/BRIEF.md
# Dual-Spacer Sleep-Controlled Threshold Gate Stage

This block is a row of dual-rail threshold gates whose registered outputs are steered by two sleep controls. With both controls low, each gate watches a window of dual-rail input digits and raises its true rail or its false rail once enough digits agree. It then keeps that rail until a spacer is applied. Raising `s0` parks every output rail at 0, the all-zero spacer. Raising `s1` parks every output rail at 1, the all-one spacer. The gates have no hysteresis of their own, so the spacer is the only way to clear a held result.

Raising both controls at once is an illegal code. The stage flags it on `ctrl_err` for one cycle and leaves every output exactly as it was. A small state machine tracks the stage mode: `ST_SPC0` (the reset state), `ST_SPC1`, `ST_EVAL` and `ST_FAULT`. On every clock edge it moves to the state named by the sampled code, from any state. Code {s0,s1}=00 leads to `ST_EVAL`, 10 to `ST_SPC0`, 01 to `ST_SPC1` and 11 to `ST_FAULT`. The next valid code always takes the stage out of `ST_FAULT`.

Gate g reads the digits at indices (g*STRIDE + k) mod NUM_IN for k = 0 .. GATE_N-1. Neighbouring windows therefore overlap and wrap around the input vector.

Top module: `dual_spacer_stage`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows every output rail at 0 and `ctrl_err` at 0, whatever `s0` and `s1` are.
- R2: When {s0,s1}=10 is sampled, every `dout_t` and `dout_f` bit is 0 one cycle later.
- R3: When {s0,s1}=01 is sampled, every `dout_t` and `dout_f` bit is 1 one cycle later.
- R4: When {s0,s1}=11 is sampled, `ctrl_err` is 1 one cycle later and every output rail keeps its previous value.
- R5: When a valid code (00, 10 or 01) is sampled, `ctrl_err` is 0 one cycle later.
- R6: In evaluation ({s0,s1}=00), input digit i counts as a logic 1 when (din_t[i],din_f[i])=(1,0) and as a logic 0 when it is (0,1). The pairs (0,0) and (1,1) count as neither. Gate g reads digits (g*STRIDE+k) mod NUM_IN for k in 0..GATE_N-1. If the gate is not holding a result, its true rail sets when at least TH_M of its digits are logic 1, and its false rail sets when at least GATE_N-TH_M+1 are logic 0.
- R7: In evaluation, a gate that holds no result (its rails are 00 or 11) and reaches neither threshold outputs 00. This includes the first cycle after the all-one spacer.
- R8: In evaluation, a gate with exactly one rail high keeps both rails unchanged, whatever its input digits do.
- R9: A result held before an illegal code is still held when evaluation resumes after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs are registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset to the all-zero spacer |
| din_t | input | NUM_IN | True rail of each input digit |
| din_f | input | NUM_IN | False rail of each input digit |
| s0 | input | 1 | Sleep control toward the all-zero spacer |
| s1 | input | 1 | Sleep control toward the all-one spacer |
| dout_t | output | NUM_GATES | True rail of each gate output |
| dout_f | output | NUM_GATES | False rail of each gate output |
| ctrl_err | output | 1 | High for one cycle after an illegal sleep code is sampled |

## Verification
The bench builds the stage with NUM_IN=6, NUM_GATES=3, GATE_N=3, TH_M=2 and STRIDE=2. With these values every window overlaps its neighbour and the last gate wraps to digit 0, so one changed digit moves two gates at once. Both thresholds equal 2, so partial data that reaches a threshold in one gate and not in another is easy to set up, as are digits with both rails high counting as neither. The sequences alternate the zero spacer, data, the one spacer and data again. Illegal codes are injected both over held results and over the one spacer.

// File: rtl/dsg_pkg.sv
package dsg_pkg;

    // sleep command, encoded as {s0, s1}
    typedef enum logic [1:0] {
        CMD_EVAL = 2'b00,
        CMD_ONE  = 2'b01,
        CMD_ZERO = 2'b10,
        CMD_BAD  = 2'b11
    } sleep_cmd_e;

    typedef enum logic [1:0] {
        ST_SPC0  = 2'b00,
        ST_SPC1  = 2'b01,
        ST_EVAL  = 2'b10,
        ST_FAULT = 2'b11
    } stage_state_e;

    function automatic sleep_cmd_e decode_sleep(input logic s0, input logic s1);
        return sleep_cmd_e'({s0, s1});
    endfunction

endpackage

// File: rtl/dsg_digit_count.sv
module dsg_digit_count #(
    parameter int WIDTH = 3,
    localparam int CW = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] rail_t,
    input  logic [WIDTH-1:0] rail_f,
    output logic [CW-1:0]    n_one,
    output logic [CW-1:0]    n_zero
);

    // a digit counts only when exactly one of its rails is high
    always_comb begin
        n_one  = '0;
        n_zero = '0;
        for (int i = 0; i < WIDTH; i++) begin
            n_one  = n_one  + CW'(rail_t[i] & ~rail_f[i]);
            n_zero = n_zero + CW'(rail_f[i] & ~rail_t[i]);
        end
    end

endmodule

// File: rtl/dsg_sleep_fsm.sv
module dsg_sleep_fsm
    import dsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       s0,
    input  logic       s1,
    output sleep_cmd_e cmd,
    output logic       ctrl_err
);

    stage_state_e state_q, state_d;

    assign cmd = decode_sleep(s0, s1);

    // next-state selection: every state follows the sampled code
    always_comb begin
        unique case (cmd)
            CMD_EVAL: state_d = ST_EVAL;
            CMD_ONE:  state_d = ST_SPC1;
            CMD_ZERO: state_d = ST_SPC0;
            CMD_BAD:  state_d = ST_FAULT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SPC0;
        else     state_q <= state_d;
    end

    // outputs
    always_comb begin
        ctrl_err = (state_q == ST_FAULT);
    end

    // R4
    bad_code_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (s0 && s1) |=> ctrl_err);

    // R5
    good_code_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(s0 && s1) |=> !ctrl_err);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (state_q == ST_SPC0) && !ctrl_err);

endmodule

// File: rtl/dsg_thresh_gate.sv
module dsg_thresh_gate
    import dsg_pkg::*;
#(
    parameter int GATE_N = 3,
    parameter int TH_M   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  sleep_cmd_e        cmd,
    input  logic [GATE_N-1:0] in_t,
    input  logic [GATE_N-1:0] in_f,
    output logic              q_t,
    output logic              q_f
);

    localparam int CW   = $clog2(GATE_N + 1);
    localparam int TH_F = GATE_N - TH_M + 1;

    logic [CW-1:0] n_one, n_zero;
    logic          hit_t, hit_f, held;
    logic          nxt_t, nxt_f;

    dsg_digit_count #(.WIDTH(GATE_N)) u_cnt (
        .rail_t (in_t),
        .rail_f (in_f),
        .n_one  (n_one),
        .n_zero (n_zero)
    );

    assign hit_t = (n_one  >= CW'(TH_M));
    assign hit_f = (n_zero >= CW'(TH_F));
    assign held  = q_t ^ q_f;

    always_comb begin
        nxt_t = q_t;
        nxt_f = q_f;
        unique case (cmd)
            CMD_ZERO: begin nxt_t = 1'b0; nxt_f = 1'b0; end
            CMD_ONE:  begin nxt_t = 1'b1; nxt_f = 1'b1; end
            CMD_BAD:  begin nxt_t = q_t;  nxt_f = q_f;  end
            CMD_EVAL: begin
                if (!held) begin
                    nxt_t = hit_t;
                    nxt_f = hit_f;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_t <= 1'b0;
            q_f <= 1'b0;
        end else begin
            q_t <= nxt_t;
            q_f <= nxt_f;
        end
    end

    // R2
    zero_spacer_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ZERO) |=> (!q_t && !q_f));

    // R3
    one_spacer_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ONE) |=> (q_t && q_f));

    // R4
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_BAD) |=> ($stable(q_t) && $stable(q_f)));

    // R8
    eval_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((cmd == CMD_EVAL) && (q_t ^ q_f)) |=> ($stable(q_t) && $stable(q_f)));

    // R6
    eval_no_double_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_EVAL) |=> !(q_t && q_f));

endmodule

// File: rtl/dual_spacer_stage.sv
module dual_spacer_stage
    import dsg_pkg::*;
#(
    parameter int NUM_IN    = 6,
    parameter int NUM_GATES = 3,
    parameter int GATE_N    = 3,
    parameter int TH_M      = 2,
    parameter int STRIDE    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_IN-1:0]    din_t,
    input  logic [NUM_IN-1:0]    din_f,
    input  logic                 s0,
    input  logic                 s1,
    output logic [NUM_GATES-1:0] dout_t,
    output logic [NUM_GATES-1:0] dout_f,
    output logic                 ctrl_err
);

    sleep_cmd_e cmd;

    dsg_sleep_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .s0       (s0),
        .s1       (s1),
        .cmd      (cmd),
        .ctrl_err (ctrl_err)
    );

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        logic [GATE_N-1:0] win_t, win_f;
        for (genvar k = 0; k < GATE_N; k++) begin : g_tap
            localparam int IDX = (g * STRIDE + k) % NUM_IN;
            assign win_t[k] = din_t[IDX];
            assign win_f[k] = din_f[IDX];
        end

        dsg_thresh_gate #(.GATE_N(GATE_N), .TH_M(TH_M)) u_gate (
            .clk  (clk),
            .rst  (rst),
            .cmd  (cmd),
            .in_t (win_t),
            .in_f (win_f),
            .q_t  (dout_t[g]),
            .q_f  (dout_f[g])
        );
    end

    // R4
    flag_freezes_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_err |-> ($stable(dout_t) && $stable(dout_f)));

    // R1
    reset_rails_chk: assert property (@(posedge clk)
        rst |=> (dout_t == '0) && (dout_f == '0));

endmodule

// File: tb/dual_spacer_stage_test.sv
module dual_spacer_stage_test;

    localparam int NI = 6;
    localparam int NG = 3;
    localparam int GN = 3;
    localparam int TM = 2;
    localparam int ST = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NI-1:0] din_t = '0, din_f = '0;
    logic          s0 = 1'b0, s1 = 1'b0;
    logic [NG-1:0] dout_t, dout_f;
    logic          ctrl_err;

    logic [NG-1:0] exp_t = '0, exp_f = '0;
    logic          exp_err = 1'b0;
    int            checks = 0, failures = 0;

    always #4 clk = ~clk;

    dual_spacer_stage #(.NUM_IN(NI), .NUM_GATES(NG), .GATE_N(GN), .TH_M(TM), .STRIDE(ST)) uut (
        .clk(clk), .rst(rst), .din_t(din_t), .din_f(din_f), .s0(s0), .s1(s1),
        .dout_t(dout_t), .dout_f(dout_f), .ctrl_err(ctrl_err)
    );

    // behaviour model taken from the requirements
    task automatic model_update();
        if (rst) begin
            exp_t = '0; exp_f = '0; exp_err = 1'b0;
        end else if (s0 && s1) begin
            exp_err = 1'b1;
        end else begin
            exp_err = 1'b0;
            if (s0)      begin exp_t = '0; exp_f = '0; end
            else if (s1) begin exp_t = '1; exp_f = '1; end
            else begin
                for (int g = 0; g < NG; g++) begin
                    if (exp_t[g] == exp_f[g]) begin
                        int c1 = 0, c0 = 0;
                        for (int k = 0; k < GN; k++) begin
                            int i = (g * ST + k) % NI;
                            if (din_t[i] && !din_f[i]) c1++;
                            if (din_f[i] && !din_t[i]) c0++;
                        end
                        exp_t[g] = (c1 >= TM);
                        exp_f[g] = (c0 >= GN - TM + 1);
                    end
                end
            end
        end
    endtask

    task automatic check_all(input string tag);
        for (int g = 0; g < NG; g++) begin
            checks++;
            if (dout_t[g] !== exp_t[g] || dout_f[g] !== exp_f[g]) begin
                failures++;
                $display("FAIL %s gate %0d rails actual=%b%b expected=%b%b",
                         tag, g, dout_t[g], dout_f[g], exp_t[g], exp_f[g]);
            end
        end
        checks++;
        if (ctrl_err !== exp_err) begin
            failures++;
            $display("FAIL %s ctrl_err actual=%b expected=%b", tag, ctrl_err, exp_err);
        end
    endtask

    // called at a falling edge: drive, let one rising edge pass, check
    task automatic step(input logic a0, input logic a1,
                        input logic [NI-1:0] vt, input logic [NI-1:0] vf,
                        input string tag);
        s0 = a0; s1 = a1; din_t = vt; din_f = vf;
        @(posedge clk);
        #1 model_update();
        @(negedge clk);
        check_all(tag);
    endtask

    // evaluation with digits: value bits v, valid mask m
    task automatic data(input logic [NI-1:0] v, input logic [NI-1:0] m, input string tag);
        step(1'b0, 1'b0, v & m, ~v & m, tag);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(1'b0, 1'b1, '1, '0, "R1");
        step(1'b1, 1'b1, '0, '1, "R1");
        rst = 1'b0;
    endtask

    task automatic t_zero_spacer();
        step(1'b1, 1'b0, 6'b101010, 6'b010101, "R2");
        step(1'b1, 1'b0, '1, '1, "R2");
    endtask

    task automatic t_one_spacer();
        step(1'b0, 1'b1, 6'b000000, 6'b111111, "R3");
        step(1'b0, 1'b1, '0, '0, "R5");
    endtask

    task automatic t_all_ones_data();
        data(6'b111111, 6'b111111, "R6");
    endtask

    task automatic t_mixed_data();
        data(6'b011001, 6'b111111, "R6");
    endtask

    task automatic t_null_after_one();
        t_one_spacer();
        data('0, '0, "R7");
        step(1'b0, 1'b0, '1, '1, "R7");
        data(6'b000001, 6'b000001, "R7");
        data(6'b000011, 6'b000011, "R6");
        data(6'b000000, 6'b011111, "R6");
    endtask

    task automatic t_hold();
        t_zero_spacer();
        data(6'b000111, 6'b000111, "R6");
        data(6'b111000, 6'b111111, "R8");
        data(6'b000000, 6'b111111, "R8");
        data('0, '0, "R8");
    endtask

    task automatic t_fault();
        t_zero_spacer();
        data(6'b110011, 6'b111111, "R6");
        step(1'b1, 1'b1, '0, '1, "R4");
        step(1'b1, 1'b1, '1, '0, "R4");
        data(6'b001100, 6'b111111, "R9");
        t_one_spacer();
        step(1'b1, 1'b1, '0, '0, "R4");
        step(1'b1, 1'b0, '0, '0, "R5");
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_zero_spacer();
        t_all_ones_data();
        t_one_spacer();
        t_mixed_data();
        t_null_after_one();
        t_hold();
        t_fault();
        t_zero_spacer();
        data(6'b000000, 6'b111111, "R6");
        rst = 1'b1;
        step(1'b0, 1'b0, '0, '0, "R1");
        rst = 1'b0;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule